// File: doc/BRIEF.md
# Receive Buffer with Windowed Read and Bulk Release

This block holds the bytes that a serial receiver delivers until the host takes them. Incoming bytes are written into a 1024-entry byte store. The host does not pop bytes one at a time. It reads them through an address window, where each offset selects a position counted from the oldest byte still held. When it has copied a batch, it writes the size of that batch once. That write frees the space and moves the oldest-byte position forward by that amount.

Two indications tell the host when to drain the buffer. A data-available level is raised when the fill count reaches a threshold that a 3-bit code selects. A character-timeout flag is raised when a partly filled buffer has been quiet for a programmable time. That time is measured in units of four baud-divisor periods, so it follows the line rate. Together these cover both bulk traffic and short trailing messages.

Top module: `rxbuf_bulk_ack`

## Requirements
- R1: After reset the fill count is 0, data-available, character-timeout and overrun are low, and the window read data is 0.
- R2: Each byte presented with `rx_valid` while the fill count is below 1023 is stored and raises the 10-bit fill count by one. The usable capacity is 1023 bytes.
- R3: Window offsets 4 to 1023 return, one clock after the offset is applied, the byte that lies (offset − 4) positions after the oldest unreleased byte. Offsets 0 to 3 return 0. The last accepted position the window can reach is therefore 1019.
- R4: A release write of count N frees min(N, fill count) bytes. The oldest-byte position advances by exactly that amount, so a count larger than the fill count empties the buffer.
- R5: The trigger code L (0 to 7) selects a threshold of 2^(L+2) bytes. Code 0 is 4, code 6 is 256 and code 7 is 512. Data-available is high whenever the fill count is at or above the threshold.
- R6: A byte arriving while the fill count is 1023 is discarded. It leaves contents and fill count unchanged, and `overrun` pulses high for exactly one clock.
- R7: When a byte arrives and a release is written in the same clock, the fill count becomes fill + 1 − released. Whether the byte is accepted depends on the fill count before that clock.
- R8: The character-timeout flag rises T × 4 × max(baud_div, 1) clocks after the last received byte or release write, where T is the timeout value. It rises only while the fill count is nonzero and below the threshold.
- R9: After reset the timeout value is 4. A timeout write of 0 is ignored and the previous value is kept.
- R10: The character-timeout flag is cleared by the next received byte or release write. It never rises while the buffer is empty or at or above the threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| rd_addr | input | 10 | Byte offset into the read window |
| rd_data | output | 8 | Window read data, one cycle after `rd_addr` |
| ack_wr | input | 1 | Release write strobe |
| ack_cnt | input | 10 | Number of bytes the host consumed |
| trig_lvl | input | 3 | Fill-level trigger code |
| baud_div | input | 16 | Baud divisor, scales the timeout unit |
| tmo_wr | input | 1 | Timeout value write strobe |
| tmo_val | input | 16 | Timeout value in units of four divisor periods |
| fill_cnt | output | 10 | Bytes currently held |
| data_avail | output | 1 | Fill count at or above the trigger threshold |
| char_tmo | output | 1 | Character timeout on a partly filled buffer |
| overrun | output | 1 | One-clock pulse when a byte is dropped on a full buffer |

## Verification
A received byte and a release write can land in the same clock. That one edge then adds to and subtracts from the fill count, moves both pointers and restarts the timeout. The bench provokes this by raising `rx_valid` and `ack_wr` together. The coincident byte is then expected to be the sole remaining entry, at window offset 4, with a fill count of one. The bench also holds the buffer at exactly 1023 and pushes one more byte. This shows that the full check uses the count from before that edge, that the overrun pulse lasts a single clock, and that the dropped value is never seen through the window.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  // First window offset that maps onto stored data.
  localparam int unsigned WIN_BASE = 4;

  // Fill level at which data-available is raised for a trigger code.
  function automatic int unsigned trig_threshold(input int unsigned code);
    return 32'd1 << (code + 32'd2);
  endfunction

  // Number of bytes a release write actually frees.
  function automatic int unsigned release_amount(input int unsigned req,
                                                 input int unsigned held);
    return (req > held) ? held : req;
  endfunction

  // Slot distance from the oldest byte for a window offset (offset >= WIN_BASE).
  function automatic int unsigned window_slot(input int unsigned off);
    return off - WIN_BASE;
  endfunction

  // Clocks per timeout unit for a baud divisor.
  function automatic int unsigned tick_period(input int unsigned div);
    return ((div == 0) ? 32'd1 : div) * 32'd4;
  endfunction

endpackage

// File: rtl/rxb_level.sv
module rxb_level
  import rxb_pkg::*;
#(
  parameter int AW     = 10,
  parameter int TRIG_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              ack_wr,
  input  logic [AW-1:0]     ack_cnt,
  input  logic [TRIG_W-1:0] trig_lvl,
  output logic [AW-1:0]     fill,
  output logic [AW-1:0]     rd_ptr,
  output logic              push_ok,
  output logic              data_avail,
  output logic              overrun
);
  localparam logic [AW-1:0] FULL_LVL = {AW{1'b1}};

  logic [AW-1:0] fill_q, rd_q, rel_w;
  logic          full_w, ovr_q;

  assign full_w  = (fill_q == FULL_LVL);
  assign push_ok = rx_valid && !full_w;
  assign rel_w   = ack_wr ? AW'(release_amount(32'(ack_cnt), 32'(fill_q))) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= '0;
      rd_q   <= '0;
      ovr_q  <= 1'b0;
    end else begin
      fill_q <= fill_q + AW'(push_ok) - rel_w;
      rd_q   <= rd_q + rel_w;
      ovr_q  <= rx_valid && full_w;
    end
  end

  assign fill       = fill_q;
  assign rd_ptr     = rd_q;
  assign overrun    = ovr_q;
  assign data_avail = (32'(fill_q) >= trig_threshold(32'(trig_lvl)));

  // R6: an overrun pulse follows only a byte offered to a full buffer
  assert_overrun_on_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(fill_q == FULL_LVL));

  // R6: a dropped byte with no release leaves the fill count alone
  assert_drop_keeps_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && full_w && !ack_wr) |=> $stable(fill_q));

  // R4: a release never lets the count grow, and the pointer moves by what was freed
  assert_release_moves_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !rx_valid) |=> ((fill_q <= $past(fill_q)) &&
                               ((rd_q - $past(rd_q)) == ($past(fill_q) - fill_q))));

  // R2: a stored byte without release adds exactly one
  assert_push_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !ack_wr) |=> (fill_q == $past(fill_q) + AW'(1)));
endmodule

// File: rtl/rxb_store.sv
module rxb_store
  import rxb_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_ok,
  input  logic [7:0]    wr_byte,
  input  logic [AW-1:0] rd_ptr,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_q, slot_w;
  logic          in_win;

  assign in_win = (32'(rd_addr) >= WIN_BASE);
  assign slot_w = rd_ptr + AW'(window_slot(32'(rd_addr)));

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= wr_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_data <= '0;
    end else begin
      if (push_ok) wr_q <= wr_q + AW'(1);
      rd_data <= in_win ? mem[slot_w] : 8'h00;
    end
  end

  // R3: the offsets below the window always read as zero
  assert_low_offsets_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rd_addr) < WIN_BASE) |=> (rd_data == 8'h00));
endmodule

// File: rtl/rxb_timeout.sv
module rxb_timeout
  import rxb_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int TMO_W       = 16,
  parameter int TMO_DEFAULT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             armed,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             tmo_wr,
  input  logic [TMO_W-1:0] tmo_val,
  output logic             char_tmo
);
  localparam int PRE_W = DIV_W + 2;

  logic [TMO_W-1:0] limit_q, units_q;
  logic [PRE_W-1:0] pre_q;
  logic             flag_q, unit_end;

  assign unit_end = (32'(pre_q) == tick_period(32'(baud_div)) - 32'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit_q <= TMO_W'(TMO_DEFAULT);
    end else if (tmo_wr && (tmo_val != '0)) begin
      limit_q <= tmo_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !armed) begin
      pre_q   <= '0;
      units_q <= '0;
      flag_q  <= 1'b0;
    end else if (!flag_q) begin
      if (unit_end) begin
        pre_q <= '0;
        if (units_q == limit_q - TMO_W'(1)) flag_q <= 1'b1;
        else                                units_q <= units_q + TMO_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

  assign char_tmo = flag_q;

  // R10: the flag is only ever raised while the buffer was partly filled
  assert_rise_when_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(char_tmo) |-> $past(armed && !restart));

  // R10: activity clears the flag on the next edge
  assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !char_tmo);

  // R9: the timeout value never holds zero
  assert_limit_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    limit_q != '0);
endmodule

// File: rtl/rxbuf_bulk_ack.sv
module rxbuf_bulk_ack
  import rxb_pkg::*;
#(
  parameter int AW          = 10,
  parameter int TRIG_W      = 3,
  parameter int DIV_W       = 16,
  parameter int TMO_W       = 16,
  parameter int TMO_DEFAULT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic [AW-1:0]     rd_addr,
  output logic [7:0]        rd_data,
  input  logic              ack_wr,
  input  logic [AW-1:0]     ack_cnt,
  input  logic [TRIG_W-1:0] trig_lvl,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              tmo_wr,
  input  logic [TMO_W-1:0]  tmo_val,
  output logic [AW-1:0]     fill_cnt,
  output logic              data_avail,
  output logic              char_tmo,
  output logic              overrun
);
  logic [AW-1:0] rd_ptr_w;
  logic          push_ok_w, activity_w, armed_w;

  rxb_level #(.AW(AW), .TRIG_W(TRIG_W)) u_level (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .ack_wr(ack_wr),
    .ack_cnt(ack_cnt), .trig_lvl(trig_lvl), .fill(fill_cnt), .rd_ptr(rd_ptr_w),
    .push_ok(push_ok_w), .data_avail(data_avail), .overrun(overrun)
  );

  rxb_store #(.AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .push_ok(push_ok_w), .wr_byte(rx_byte),
    .rd_ptr(rd_ptr_w), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign activity_w = rx_valid || ack_wr;
  assign armed_w    = (fill_cnt != '0) && !data_avail;

  rxb_timeout #(.DIV_W(DIV_W), .TMO_W(TMO_W), .TMO_DEFAULT(TMO_DEFAULT)) u_tmo (
    .clk(clk), .rst_n(rst_n), .restart(activity_w), .armed(armed_w),
    .baud_div(baud_div), .tmo_wr(tmo_wr), .tmo_val(tmo_val), .char_tmo(char_tmo)
  );

  // R8: a raised timeout implies a nonempty buffer
  assert_tmo_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    char_tmo |-> (fill_cnt != '0));
endmodule

// File: tb/rxbuf_bulk_ack_test.sv
`timescale 1ns/1ps
module rxbuf_bulk_ack_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [9:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic ack_wr = 1'b0;
  logic [9:0] ack_cnt = '0;
  logic [2:0] trig_lvl = 3'd7;
  logic [15:0] baud_div = 16'd1;
  logic tmo_wr = 1'b0;
  logic [15:0] tmo_val = '0;
  logic [9:0] fill_cnt;
  logic data_avail, char_tmo, overrun;

  int checks = 0;
  int errors = 0;
  int seq = 0;       // accepted bytes so far (byte k carries value k mod 256)
  int released = 0;  // bytes released so far

  always #10 clk = ~clk;

  rxbuf_bulk_ack uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rd_addr(rd_addr), .rd_data(rd_data), .ack_wr(ack_wr), .ack_cnt(ack_cnt),
    .trig_lvl(trig_lvl), .baud_div(baud_div), .tmo_wr(tmo_wr), .tmo_val(tmo_val),
    .fill_cnt(fill_cnt), .data_avail(data_avail), .char_tmo(char_tmo),
    .overrun(overrun)
  );

  typedef struct packed {
    logic [10:0] n_push;
    logic [9:0]  n_ack;
    logic [2:0]  trig;
    logic [9:0]  exp_fill;
    logic        exp_avail;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{11'd5,  10'd0,   3'd0, 10'd5,  1'b1},
    '{11'd0,  10'd2,   3'd0, 10'd3,  1'b0},
    '{11'd10, 10'd0,   3'd2, 10'd13, 1'b0},
    '{11'd3,  10'd0,   3'd2, 10'd16, 1'b1},
    '{11'd0,  10'd100, 3'd2, 10'd0,  1'b0},
    '{11'd40, 10'd8,   3'd3, 10'd32, 1'b1},
    '{11'd0,  10'd1,   3'd3, 10'd31, 1'b0},
    '{11'd0,  10'd31,  3'd0, 10'd0,  1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_burst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_byte = 8'(seq); seq++;
    end
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic release_n(input int n, input int held);
    @(negedge clk); ack_wr = 1'b1; ack_cnt = 10'(n);
    @(negedge clk); ack_wr = 1'b0;
    released += (n > held) ? held : n;
  endtask

  task automatic read_win(input int off, output int d);
    @(negedge clk); rd_addr = 10'(off);
    @(negedge clk); d = int'(rd_data);
  endtask

  task automatic count_tmo(output int n);
    n = 0;
    while (!char_tmo && n < 5000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d, n, model_fill;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fill", int'(fill_cnt), 0);
    chk("R1 avail", int'(data_avail), 0);
    chk("R1 tmo", int'(char_tmo), 0);
    chk("R1 overrun", int'(overrun), 0);
    chk("R1 rd_data", int'(rd_data), 0);

    // R9 default timeout value 4, baud_div 1 -> 16 clocks (R8)
    push_burst(1);
    count_tmo(n);
    chk("R9 default timeout clocks", n, 16);
    release_n(1, 1);
    chk("R10 release clears tmo", int'(char_tmo), 0);

    // Vector table: R2 R4 R5 R3
    model_fill = 0;
    foreach (VECS[i]) begin
      @(negedge clk); trig_lvl = VECS[i].trig;
      push_burst(int'(VECS[i].n_push));
      model_fill += int'(VECS[i].n_push);
      if (VECS[i].n_ack != 0) begin
        release_n(int'(VECS[i].n_ack), model_fill);
        model_fill = seq - released;
      end
      chk("R2/R4 fill", int'(fill_cnt), int'(VECS[i].exp_fill));
      chk("R4 model fill", int'(fill_cnt), model_fill);
      chk("R5 data_avail", int'(data_avail), int'(VECS[i].exp_avail));
      if (model_fill > 0) begin
        read_win(4, d);
        chk("R3 oldest byte", d, released & 255);
        read_win(3 + model_fill, d);
        chk("R3 newest byte", d, (seq - 1) & 255);
      end
    end
    read_win(1, d);
    chk("R3 low offset zero", d, 0);

    // Fill to capacity, R2/R5 code 7
    @(negedge clk); trig_lvl = 3'd7;
    push_burst(1023);
    chk("R2 full count", int'(fill_cnt), 1023);
    chk("R5 code7 avail", int'(data_avail), 1);
    // R6 drop on full
    @(negedge clk); rx_valid = 1'b1; rx_byte = 8'hEE;
    @(negedge clk); rx_valid = 1'b0;
    chk("R6 overrun pulse", int'(overrun), 1);
    chk("R6 fill unchanged", int'(fill_cnt), 1023);
    @(negedge clk);
    chk("R6 overrun one clock", int'(overrun), 0);
    read_win(10'h3FF, d);
    chk("R3 top offset", d, (released + 1019) & 255);
    release_n(1020, 1023);
    chk("R4 bulk release", int'(fill_cnt), 3);
    read_win(6, d);
    chk("R6 last stored byte not dropped value", d, (seq - 1) & 255);

    // R7 coincident byte and release
    @(negedge clk); rx_valid = 1'b1; rx_byte = 8'(seq); ack_wr = 1'b1; ack_cnt = 10'd3;
    @(negedge clk); rx_valid = 1'b0; ack_wr = 1'b0;
    seq++; released += 3;
    chk("R7 coincident fill", int'(fill_cnt), 1);
    read_win(4, d);
    chk("R7 coincident byte", d, (seq - 1) & 255);

    // R8 programmed timeout: T=3, div=2 -> 24 clocks
    @(negedge clk); baud_div = 16'd2; tmo_wr = 1'b1; tmo_val = 16'd3;
    @(negedge clk); tmo_wr = 1'b0;
    push_burst(1);
    count_tmo(n);
    chk("R8 timeout clocks", n, 24);
    push_burst(1);
    chk("R10 byte clears tmo", int'(char_tmo), 0);
    // R9 zero write ignored
    @(negedge clk); tmo_wr = 1'b1; tmo_val = 16'd0;
    @(negedge clk); tmo_wr = 1'b0;
    release_n(1, 3);
    count_tmo(n);
    chk("R9 zero write ignored", n, 24);
    // R10 no timeout at threshold
    @(negedge clk); trig_lvl = 3'd0;
    push_burst(2);
    chk("R5 at threshold", int'(data_avail), 1);
    repeat (100) @(negedge clk);
    chk("R10 no tmo at threshold", int'(char_tmo), 0);
    // R10 no timeout when empty
    release_n(1023, int'(fill_cnt));
    chk("R4 clamp to empty", int'(fill_cnt), 0);
    repeat (100) @(negedge clk);
    chk("R10 no tmo when empty", int'(char_tmo), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule